// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Decoder

This block is a synthesizable, device-side model of the control logic inside a four-bit-wide asynchronous DRAM. A fast system clock oversamples the active-low row strobe, column strobe, write enable and output enable. Address and input data travel through the same synchroniser pipeline, so every strobe edge lines up with the values that were present when it was sampled. The decoder classifies each row-strobe falling edge by the state of the other strobes at that moment. It then runs a normal access (random or page-mode), a row-only refresh, a counter-driven refresh, a test-mode entry, or a counter test access. During a counter test access the row comes from the internal refresh counter.

The storage is a small register array of ROWS x COLS four-bit words. In compressed test mode one write puts input bit 0 into all sixteen cells of a four-column group. The two lowest column bits are ignored for this. A read in that mode reports on every data line whether those sixteen cells agree.

Top module: `dram_strobe_ctl`

## Requirements
- R1: While reset is held and after it is released, the data outputs are disabled (`dq_oe` low, `dq_out` all zero), test mode is off and the refresh counter is zero.
- R2: A row-strobe falling edge with the column strobe high latches the row from `addr`. If no column strobe fall follows before the row strobe rises, the cycle is a row-only refresh: the outputs stay disabled throughout and test mode is cleared.
- R3: A row-strobe falling edge with the column strobe already low is a counter refresh. The row refreshed is the counter value, and the 12-bit counter then advances by exactly one and wraps. A sample in which both strobes fall together counts as column-first.
- R4: A counter refresh with write enable low enters test mode. Test mode ends at a later counter refresh with write enable high, or at a row-only refresh.
- R5: In a read (write enable high at the column fall), `dq_out` shows the stored word at the latched row and column. The outputs stay disabled until the column strobe falls and are disabled again once it rises.
- R6: If write enable is low at the column-strobe fall (including a fall in the same sample), `dq_in` is written at that fall and the outputs stay disabled for the whole column cycle.
- R7: If write enable falls while the column strobe is already low, the data present at that write-enable fall is written. The later of the two falls is always the data strobe.
- R8: While the row strobe stays low, successive column cycles reuse the latched row with new column addresses, in any mix of reads and writes.
- R9: In test mode a write stores `dq_in[0]` into all four bits of the four columns that share column bits above bit 1. Cells outside that group are untouched.
- R10: In a test-mode read every `dq_out` line is 1 when all sixteen cells of the group are equal and 0 when they differ.
- R11: After a counter refresh, a column-strobe rise and second fall with the row strobe still low starts a counter test access. Its row is the counter value used by that refresh and its column is `addr` at the second fall. Both reads and writes work.
- R12: Raising and lowering the row strobe while the column strobe is held low from a read performs a counter refresh. The read data stays on `dq_out` during it.
- R13: With output enable high, the outputs stay disabled regardless of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | max(log2 ROWS, log2 COLS) | Multiplexed row/column address |
| dq_in | input | DQW | Write data |
| dq_out | output | DQW | Read data, zero when disabled |
| dq_oe | output | 1 | High while the model drives read data |

## Verification
Two functions can land in the same oversampled cycle in this block. In one case write enable and the column strobe fall together, and the decoder must treat this as an early write. In the other, the row strobe cycles under a held column strobe, so a refresh decode coincides with a live read output. The bench provokes both on purpose: early writes drive both strobes low on one edge, and the hidden-refresh sequence toggles the row strobe mid-read. A behavioural model fed with the same raw pins judges both cases. It must predict the written cell and the unchanged output word on each clock.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE    = 2'd0,
    CYC_ACCESS  = 2'd1,
    CYC_REFRESH = 2'd2,
    CYC_CTEST   = 2'd3
  } cyc_mode_t;

  localparam int unsigned GROUP_COLS = 4;

  // flat cell index of a (row, column) pair
  function automatic int unsigned cell_index(input int unsigned row,
                                             input int unsigned col,
                                             input int unsigned cols);
    return row * cols + col;
  endfunction

  // column j of the compressed group that holds column col
  function automatic int unsigned group_col(input int unsigned col,
                                            input int unsigned j);
    return (col & ~(GROUP_COLS - 1)) + j;
  endfunction

endpackage

// File: rtl/dsd_sync_pipe.sv
module dsd_sync_pipe #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsd_cell_array.sv
module dsd_cell_array
  import dsd_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  parameter int DQW  = 4,
  localparam int RB = $clog2(ROWS),
  localparam int CB = $clog2(COLS)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic           wr_bulk,
  input  logic [RB-1:0]  wr_row,
  input  logic [CB-1:0]  wr_col,
  input  logic [DQW-1:0] wr_data,
  input  logic [RB-1:0]  rd_row,
  input  logic [CB-1:0]  rd_col,
  output logic [DQW-1:0] rd_word,
  output logic           rd_agree
);
  localparam int DEPTH = ROWS * COLS;
  localparam int GBITS = GROUP_COLS * DQW;

  logic [DQW-1:0]   mem [DEPTH];
  logic [GBITS-1:0] grp;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_bulk) begin
        for (int j = 0; j < GROUP_COLS; j++)
          mem[cell_index(wr_row, group_col(wr_col, j), COLS)] <= {DQW{wr_data[0]}};
      end else begin
        mem[cell_index(wr_row, wr_col, COLS)] <= wr_data;
      end
    end
  end

  always_comb begin
    for (int j = 0; j < GROUP_COLS; j++)
      grp[j*DQW +: DQW] = mem[cell_index(rd_row, group_col(rd_col, j), COLS)];
  end

  assign rd_word  = mem[cell_index(rd_row, rd_col, COLS)];
  assign rd_agree = (grp == '0) || (grp == '1);
endmodule

// File: rtl/dsd_cycle_ctrl.sv
module dsd_cycle_ctrl
  import dsd_pkg::*;
#(
  parameter int RB    = 4,
  parameter int CB    = 4,
  parameter int AW    = 4,
  parameter int DQW   = 4,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_l,
  input  logic             cas_l,
  input  logic             we_l,
  input  logic [AW-1:0]    addr,
  input  logic [DQW-1:0]   din,
  output logic [RB-1:0]    acc_row,
  output logic [CB-1:0]    acc_col,
  output logic [RB-1:0]    wr_row,
  output logic [CB-1:0]    wr_col,
  output logic [DQW-1:0]   wr_data,
  output logic             wr_en,
  output logic             test_mode,
  output logic             col_valid,
  output logic             early_wr,
  output logic [CNT_W-1:0] ref_cnt,
  output logic [RB-1:0]    ref_row,
  output logic             ev_row_open,
  output logic             ev_cbr,
  output logic             ev_test_entry,
  output logic             ev_ras_only,
  output logic             ev_ctest_start,
  output logic             ev_wr_early,
  output logic             ev_wr_late
);
  cyc_mode_t mode;
  logic ras_p, cas_p, we_p;
  logic cas_seen, ctest_arm;
  logic ras_fell, ras_rose, cas_fell, cas_rose, we_fell, col_next, col_latch;

  assign ras_fell = ras_p & ~ras_l;
  assign ras_rose = ~ras_p & ras_l;
  assign cas_fell = cas_p & ~cas_l;
  assign cas_rose = ~cas_p & cas_l;
  assign we_fell  = we_p & ~we_l;

  assign ev_row_open    = ras_fell & cas_l;
  assign ev_cbr         = ras_fell & ~cas_l & we_l;
  assign ev_test_entry  = ras_fell & ~cas_l & ~we_l;
  assign ev_ras_only    = ras_rose & (mode == CYC_ACCESS) & ~cas_seen;
  assign ev_ctest_start = cas_fell & ~ras_l & (mode == CYC_REFRESH) & ctest_arm;
  assign col_next       = cas_fell & ~ras_l & ((mode == CYC_ACCESS) | (mode == CYC_CTEST));
  assign col_latch      = col_next | ev_ctest_start;
  assign ev_wr_early    = col_latch & ~we_l;
  assign ev_wr_late     = we_fell & ~cas_l & col_valid & ~early_wr;

  assign wr_en   = ev_wr_early | ev_wr_late;
  assign wr_row  = ev_ctest_start ? ref_row : acc_row;
  assign wr_col  = col_latch ? addr[CB-1:0] : acc_col;
  assign wr_data = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
      we_p  <= 1'b1;
    end else begin
      ras_p <= ras_l;
      cas_p <= cas_l;
      we_p  <= we_l;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= CYC_IDLE;
      acc_row   <= '0;
      acc_col   <= '0;
      ref_cnt   <= '0;
      ref_row   <= '0;
      test_mode <= 1'b0;
      cas_seen  <= 1'b0;
      ctest_arm <= 1'b0;
      col_valid <= 1'b0;
      early_wr  <= 1'b0;
    end else begin
      if (ras_fell)            mode <= cas_l ? CYC_ACCESS : CYC_REFRESH;
      else if (ras_rose)       mode <= CYC_IDLE;
      else if (ev_ctest_start) mode <= CYC_CTEST;

      if (ev_row_open)         acc_row <= addr[RB-1:0];
      else if (ev_ctest_start) acc_row <= ref_row;
      if (col_latch)           acc_col <= addr[CB-1:0];

      if (ev_cbr | ev_test_entry) begin
        ref_row <= ref_cnt[RB-1:0];
        ref_cnt <= ref_cnt + 1'b1;
      end

      if (ev_test_entry)              test_mode <= 1'b1;
      else if (ev_cbr | ev_ras_only)  test_mode <= 1'b0;

      if (ras_fell)       cas_seen <= 1'b0;
      else if (col_latch) cas_seen <= 1'b1;

      if (ras_fell) ctest_arm <= 1'b0;
      else if (cas_rose & ~ras_l & (mode == CYC_REFRESH)) ctest_arm <= 1'b1;

      if (col_latch)     col_valid <= 1'b1;
      else if (cas_rose) col_valid <= 1'b0;

      if (ev_wr_early)   early_wr <= 1'b1;
      else if (cas_rose) early_wr <= 1'b0;
    end
  end
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
  parameter int ROWS        = 16,
  parameter int COLS        = 16,
  parameter int DQW         = 4,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  localparam int RB = $clog2(ROWS),
  localparam int CB = $clog2(COLS),
  localparam int AW = (RB > CB) ? RB : CB
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic           oe_n,
  input  logic [AW-1:0]  addr,
  input  logic [DQW-1:0] dq_in,
  output logic [DQW-1:0] dq_out,
  output logic           dq_oe
);
  localparam int PW = 4 + AW + DQW;
  localparam logic [PW-1:0] PIPE_RST = {4'b1111, {(AW + DQW){1'b0}}};

  logic [PW-1:0]    pipe_q;
  logic             ras_s, cas_s, we_s, oe_s;
  logic [AW-1:0]    addr_s;
  logic [DQW-1:0]   din_s;

  logic [RB-1:0]    acc_row, wr_row, ref_row;
  logic [CB-1:0]    acc_col, wr_col;
  logic [DQW-1:0]   wr_data, rd_word, rd_data;
  logic             wr_en, test_mode, col_valid, early_wr, rd_agree;
  logic [CNT_W-1:0] ref_cnt;
  logic             ev_row_open, ev_cbr, ev_test_entry, ev_ras_only;
  logic             ev_ctest_start, ev_wr_early, ev_wr_late;

  dsd_sync_pipe #(.WIDTH(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIPE_RST)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({oe_n, we_n, cas_n, ras_n, addr, dq_in}),
    .q(pipe_q)
  );

  assign {oe_s, we_s, cas_s, ras_s, addr_s, din_s} = pipe_q;

  dsd_cycle_ctrl #(.RB(RB), .CB(CB), .AW(AW), .DQW(DQW), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ras_l(ras_s), .cas_l(cas_s), .we_l(we_s),
    .addr(addr_s), .din(din_s),
    .acc_row(acc_row), .acc_col(acc_col),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .wr_en(wr_en),
    .test_mode(test_mode), .col_valid(col_valid), .early_wr(early_wr),
    .ref_cnt(ref_cnt), .ref_row(ref_row),
    .ev_row_open(ev_row_open), .ev_cbr(ev_cbr), .ev_test_entry(ev_test_entry),
    .ev_ras_only(ev_ras_only), .ev_ctest_start(ev_ctest_start),
    .ev_wr_early(ev_wr_early), .ev_wr_late(ev_wr_late)
  );

  dsd_cell_array #(.ROWS(ROWS), .COLS(COLS), .DQW(DQW)) array_i (
    .clk(clk),
    .wr_en(wr_en), .wr_bulk(test_mode),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .rd_row(acc_row), .rd_col(acc_col),
    .rd_word(rd_word), .rd_agree(rd_agree)
  );

  assign rd_data = test_mode ? {DQW{rd_agree}} : rd_word;
  assign dq_oe   = col_valid & ~early_wr & ~oe_s;
  assign dq_out  = dq_oe ? rd_data : '0;
endmodule

// File: rtl/dram_strobe_ctl_chk.sv
module dram_strobe_ctl_chk #(
  parameter int RB    = 4,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dq_oe,
  input logic             test_mode,
  input logic [CNT_W-1:0] ref_cnt,
  input logic [RB-1:0]    ref_row,
  input logic [RB-1:0]    acc_row,
  input logic             ev_row_open,
  input logic             ev_cbr,
  input logic             ev_test_entry,
  input logic             ev_ras_only,
  input logic             ev_ctest_start,
  input logic             ev_wr_early,
  input logic             ev_wr_late
);
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cbr || ev_test_entry) |=> (ref_cnt == $past(ref_cnt) + 1'b1));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_cbr || ev_test_entry) |=> $stable(ref_cnt));

  p_decode_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_row_open, ev_cbr, ev_test_entry}));

  p_tm_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_test_entry |=> test_mode);

  p_tm_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cbr || ev_ras_only) |=> !test_mode);

  p_ras_only_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ras_only |-> !dq_oe);

  p_early_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_early |=> !dq_oe);

  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_wr_early, ev_wr_late}));

  p_ctest_row_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ctest_start |=> (acc_row == $past(ref_row)));
endmodule

bind dram_strobe_ctl dram_strobe_ctl_chk #(.RB(RB), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .test_mode(test_mode),
  .ref_cnt(ref_cnt), .ref_row(ref_row), .acc_row(acc_row),
  .ev_row_open(ev_row_open), .ev_cbr(ev_cbr), .ev_test_entry(ev_test_entry),
  .ev_ras_only(ev_ras_only), .ev_ctest_start(ev_ctest_start),
  .ev_wr_early(ev_wr_early), .ev_wr_late(ev_wr_late)
);

// File: tb/dram_strobe_ctl_tb_top.sv
`timescale 1ns/1ps
module dram_strobe_ctl_tb_top;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int AW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic dq_oe;

  always #2 clk = ~clk;

  dram_strobe_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  typedef struct { bit ras; bit cas; bit we; bit oe; int addr; int din; } smp_t;
  smp_t hist[$];
  int mem[ROWS*COLS];
  int m_mode, m_cnt, m_ref, m_row, m_col;
  bit m_tm, m_cv, m_early, m_arm, m_seen, m_oe_lvl;

  function automatic int pat(int r, int c);
    return (r * 3 + c * 5) & 15;
  endfunction

  task automatic model_reset();
    smp_t s;
    s.ras = 1; s.cas = 1; s.we = 1; s.oe = 1; s.addr = 0; s.din = 0;
    hist = {s, s, s, s};
    m_mode = 0; m_cnt = 0; m_ref = 0; m_row = 0; m_col = 0;
    m_tm = 0; m_cv = 0; m_early = 0; m_arm = 0; m_seen = 0; m_oe_lvl = 1;
  endtask

  task automatic model_step();
    smp_t s, cur, prv;
    bit rf, rr, cf, cr, wf, ctst, clat, wearly, wlate;
    int o_mode, o_ref, o_row, o_col, o_cnt, wr_r, wr_c, base;
    bit o_arm, o_cv, o_early, o_seen;
    s.ras = ras_n; s.cas = cas_n; s.we = we_n; s.oe = oe_n;
    s.addr = int'(addr); s.din = int'(dq_in);
    hist.push_front(s);
    hist = hist[0:3];
    cur = hist[2]; prv = hist[3];
    rf = prv.ras && !cur.ras; rr = !prv.ras && cur.ras;
    cf = prv.cas && !cur.cas; cr = !prv.cas && cur.cas;
    wf = prv.we && !cur.we;
    o_mode = m_mode; o_ref = m_ref; o_row = m_row; o_col = m_col; o_cnt = m_cnt;
    o_arm = m_arm; o_cv = m_cv; o_early = m_early; o_seen = m_seen;
    ctst = cf && !cur.ras && o_mode == 2 && o_arm;
    clat = (cf && !cur.ras && (o_mode == 1 || o_mode == 3)) || ctst;
    wearly = clat && !cur.we;
    wlate = wf && !cur.cas && o_cv && !o_early;
    if (wearly || wlate) begin
      wr_r = ctst ? o_ref : o_row;
      wr_c = clat ? cur.addr % COLS : o_col;
      if (m_tm) begin
        base = wr_c - (wr_c % 4);
        for (int j = 0; j < 4; j++) mem[wr_r*COLS + base + j] = (cur.din & 1) ? 15 : 0;
      end else mem[wr_r*COLS + wr_c] = cur.din;
    end
    if (rf) begin
      m_seen = 0; m_arm = 0;
      if (cur.cas) begin m_mode = 1; m_row = cur.addr % ROWS; end
      else begin
        m_mode = 2; m_ref = o_cnt % ROWS; m_cnt = (o_cnt + 1) % 4096; m_tm = !cur.we;
      end
    end else if (rr) begin
      if (o_mode == 1 && !o_seen) m_tm = 0;
      m_mode = 0;
    end else if (ctst) begin
      m_mode = 3; m_row = o_ref;
    end
    if (clat) begin m_seen = 1; m_cv = 1; m_col = cur.addr % COLS; end
    if (wearly) m_early = 1;
    if (cr) begin
      m_cv = 0; m_early = 0;
      if (!cur.ras && o_mode == 2) m_arm = 1;
    end
    m_oe_lvl = hist[1].oe;
  endtask

  function automatic int model_data();
    int base, w;
    bit z, o;
    if (!m_tm) return mem[m_row*COLS + m_col];
    base = m_col - (m_col % 4);
    z = 1; o = 1;
    for (int j = 0; j < 4; j++) begin
      w = mem[m_row*COLS + base + j];
      if (w < 0) return -1;
      if (w != 0) z = 0;
      if (w != 15) o = 0;
    end
    return (z || o) ? 15 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic fail(string req, string what, int act, int exp);
    bad++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_oe, e_dq;
      e_oe = (m_cv && !m_early && !m_oe_lvl) ? 1 : 0;
      total++;
      if (int'(dq_oe) != e_oe) fail(cur_req, "dq_oe", int'(dq_oe), e_oe);
      else if (e_oe == 1) begin
        e_dq = model_data();
        if (e_dq >= 0) begin
          total++;
          if (int'(dq_out) != e_dq) fail(cur_req, "dq_out", int'(dq_out), e_dq);
        end
      end else begin
        total++;
        if (dq_out != 4'h0) fail(cur_req, "dq_out idle", int'(dq_out), 0);
      end
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic open_row(int r);
    addr = AW'(r); ras_n = 1'b0; tick(4);
  endtask

  task automatic close_row();
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(4);
  endtask

  task automatic read_check(int c, int exp, string req);
    addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; tick(5);
    check(req, "read dq_out", int'(dq_out), exp);
    cas_n = 1'b1; tick(3);
  endtask

  task automatic early_write(int c, int d);
    addr = AW'(c); dq_in = 4'(d); we_n = 1'b0; cas_n = 1'b0; tick(5);
    check("R6", "early write dq_oe", int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; tick(3);
  endtask

  task automatic late_write(int c, int d);
    addr = AW'(c); we_n = 1'b1; cas_n = 1'b0; tick(4);
    dq_in = 4'(d); we_n = 1'b0; tick(4);
    we_n = 1'b1; cas_n = 1'b1; tick(3);
  endtask

  task automatic cbr();
    cas_n = 1'b0; we_n = 1'b1; tick(3);
    ras_n = 1'b0; tick(4);
    ras_n = 1'b1; tick(2);
    cas_n = 1'b1; tick(3);
  endtask

  task automatic wcbr();
    cas_n = 1'b0; we_n = 1'b0; tick(3);
    ras_n = 1'b0; tick(4);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(3);
  endtask

  task automatic ras_only(int r);
    addr = AW'(r); ras_n = 1'b0; tick(5);
    check("R2", "row-only dq_oe", int'(dq_oe), 0);
    ras_n = 1'b1; tick(4);
  endtask

  // counter refresh followed by a second column fall under the same row strobe
  task automatic ctest(int c, bit wr, int d, int exp, string req);
    cas_n = 1'b0; we_n = 1'b1; tick(3);
    ras_n = 1'b0; tick(4);
    cas_n = 1'b1; tick(3);
    addr = AW'(c); dq_in = 4'(d); we_n = wr ? 1'b0 : 1'b1; cas_n = 1'b0; tick(5);
    if (!wr) check(req, "counter test dq_out", int'(dq_out), exp);
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; tick(4);
  endtask

  initial begin
    for (int i = 0; i < ROWS*COLS; i++) mem[i] = -1;
    model_reset();
    tick(5);
    check("R1", "reset dq_oe", int'(dq_oe), 0);
    check("R1", "reset dq_out", int'(dq_out), 0);
    rst_n = 1'b1; tick(3);

    cur_req = "R8";
    for (int r = 0; r < ROWS; r++) begin
      open_row(r);
      for (int c = 0; c < COLS; c++) early_write(c, pat(r, c));
      close_row();
    end

    cur_req = "R5";
    open_row(5);
    read_check(0, pat(5, 0), "R5");
    read_check(7, pat(5, 7), "R5");
    read_check(15, pat(5, 15), "R8");
    close_row();

    cur_req = "R13";
    open_row(9);
    oe_n = 1'b1; addr = 4'd3; cas_n = 1'b0; tick(5);
    check("R13", "oe high dq_oe", int'(dq_oe), 0);
    cas_n = 1'b1; oe_n = 1'b0; tick(3);
    close_row();

    cur_req = "R7";
    open_row(2);
    late_write(4, 4'hA);
    read_check(4, 4'hA, "R7");
    close_row();

    cur_req = "R11";
    ctest(6, 1'b0, 0, pat(0, 6), "R11");
    ctest(9, 1'b1, 3, 0, "R11");
    open_row(1);
    read_check(9, 3, "R11");
    close_row();

    cur_req = "R3";
    cbr(); cbr(); cbr();
    ctest(2, 1'b0, 0, pat(5, 2), "R3");

    cur_req = "R12";
    open_row(5);
    addr = 4'd7; we_n = 1'b1; cas_n = 1'b0; tick(5);
    ras_n = 1'b1; tick(3);
    ras_n = 1'b0; tick(5);
    check("R12", "hidden refresh dq_oe", int'(dq_oe), 1);
    check("R12", "hidden refresh dq_out", int'(dq_out), pat(5, 7));
    ras_n = 1'b1; tick(2);
    cas_n = 1'b1; tick(3);

    cur_req = "R9";
    wcbr();
    open_row(7);
    early_write(9, 4'h1);
    read_check(10, 4'hF, "R10");
    close_row();
    cur_req = "R4";
    ras_only(0);
    open_row(7);
    read_check(11, 4'hF, "R4");
    early_write(8, 4'h6);
    close_row();
    wcbr();
    cur_req = "R10";
    open_row(7);
    read_check(11, 4'h0, "R10");
    close_row();
    cur_req = "R4";
    cbr();
    open_row(7);
    read_check(8, 4'h6, "R4");
    close_row();

    cur_req = "R9";
    wcbr();
    open_row(3);
    early_write(1, 4'hE);
    close_row();
    ras_only(2);
    open_row(3);
    read_check(0, 0, "R9");
    read_check(3, 0, "R9");
    read_check(4, pat(3, 4), "R9");
    close_row();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule